// File: doc/BRIEF.md
# Bit-Plane Ping-Pong Reorder Buffer

This buffer sits between a word-serial pixel source and a bank of distributed-arithmetic transform units. It takes 9-bit two's-complement samples of one 8x8 block, one per cycle, and hands the whole block back one bit position at a time. Each output cycle carries a 64-bit vector that holds the same bit of every stored sample.

Two 64-word by 9-bit banks alternate roles. One bank fills while the other drains. Each arriving sample is placed at a scrambled location. Rows and columns are scrambled separately: even source indices go to the lower half and odd source indices go to the upper half in mirrored order. This is the data order that the direct two-dimensional transform expects.

A block is released to the read side once its 64th sample is written, and a one-cycle pulse marks the hand-over. The consumer paces the output with a ready input. If both banks are held by the read side, the write side deasserts its ready.

Top module: `bitplane_pingpong_buf`

## Requirements
- R1: After reset, out_valid and swap_pulse are 0, in_ready is 1, and no block is held.
- R2: A sample is accepted on a clock edge where in_valid and in_ready are both 1. Accepted samples fill a block in raster order: sample j has row j/8 and column j%8. Every 64 accepted samples form one block.
- R3: Output bit a of out_plane, with a = r*8+c, comes from the source sample at row p(r) and column p(c). The map is p(i)=2i for i<4 and p(i)=15-2i for i>=4.
- R4: In the cycle after the edge that accepts a block's 64th sample, swap_pulse is 1 for exactly one cycle. If the read side was idle, out_valid is 1 in that same cycle with out_bitidx 0.
- R5: A block is emitted as 9 bit planes, least significant bit first. out_bitidx counts 0 to 8 and equals the bit taken from each sample. out_last is 1 only on plane 8, the sign bit.
- R6: While out_valid is 1 and out_ready is 0, out_plane, out_bitidx and out_last hold their values.
- R7: in_ready is 0 while the bank to be written next still holds an unread block. Samples offered then are ignored and do not count toward the next block.
- R8: A block written while another is being read is emitted directly after it. Its plane 0 appears in the cycle after the earlier block's last plane is taken.
- R9: out_valid is 0 whenever no complete block is waiting to be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_data | input | 9 | Two's-complement pixel sample |
| in_ready | output | 1 | Buffer can take a sample |
| out_ready | input | 1 | Consumer takes the current plane |
| out_valid | output | 1 | out_plane holds a valid bit plane |
| out_plane | output | 64 | One bit of every stored sample, indexed by scrambled location |
| out_bitidx | output | 4 | Bit position carried by out_plane |
| out_last | output | 1 | Current plane is the sign plane |
| swap_pulse | output | 1 | One-cycle marker that a full block was handed to the read side |

## Verification
The bench drives four blocks through the buffer:
- A raster ramp, where each sample equals its own index. Any row or column scramble error shows up as a wrong bit pattern in the low planes.
- A block with a single nonzero sample. It shows that exactly one output bit moves, and to which location.
- A block of descending negative values. It exercises the upper planes and the sign plane.
- An all-ones block with one hole. It catches stuck-at-one lanes.

Two further scenarios cover flow control:
- A paused consumer, which shows that the output holds.
- Two queued blocks followed by rejected samples. This separates the write-side stall from silent data loss, and checks the gap-free seam between consecutive blocks.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
    localparam int unsigned SIDE    = 8;
    localparam int unsigned WORD_W  = 9;
    localparam int unsigned BLK     = SIDE * SIDE;
    localparam int unsigned IDX_W   = $clog2(SIDE);
    localparam int unsigned ADDR_W  = $clog2(BLK);
    localparam int unsigned PLANE_W = $clog2(WORD_W);
    localparam int unsigned BANKS   = 2;

    // Location that a source index lands on: evens fill the low half,
    // odds fill the high half in mirrored order.
    function automatic logic [IDX_W-1:0] slot_of(input logic [IDX_W-1:0] j);
        int v;
        if (j[0]) v = (2 * SIDE - 1 - int'(j)) / 2;
        else      v = int'(j) / 2;
        return IDX_W'(v);
    endfunction

    typedef struct packed {
        logic               wr_sel;
        logic [ADDR_W-1:0]  wr_cnt;
        logic               rd_sel;
        logic [PLANE_W-1:0] plane;
        logic [BANKS-1:0]   full;
        logic               swap;
    } ctrl_t;
endpackage

// File: rtl/bpr_addr_map.sv
module bpr_addr_map
    import bpr_pkg::*;
(
    input  logic [ADDR_W-1:0] raster,
    output logic [ADDR_W-1:0] slot
);
    logic [IDX_W-1:0] row, col;
    always_comb begin
        row  = raster[ADDR_W-1:IDX_W];
        col  = raster[IDX_W-1:0];
        slot = {slot_of(row), slot_of(col)};
    end
endmodule

// File: rtl/bpr_bank.sv
module bpr_bank
    import bpr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [PLANE_W-1:0] rbit,
    output logic [BLK-1:0]     plane
);
    logic [WORD_W-1:0] mem_q [BLK];
    logic [WORD_W-1:0] mem_d [BLK];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(BLK); i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar a = 0; a < int'(BLK); a++) begin : g_lane
        assign plane[a] = mem_q[a][rbit];
    end
endmodule

// File: rtl/bpr_ctrl.sv
module bpr_ctrl
    import bpr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               out_ready,
    output logic               in_ready,
    output logic               wr_fire,
    output logic               wr_sel,
    output logic [ADDR_W-1:0]  wr_cnt,
    output logic               rd_sel,
    output logic               out_valid,
    output logic [PLANE_W-1:0] out_bitidx,
    output logic               out_last,
    output logic               swap_pulse
);
    ctrl_t st_q, st_d;

    localparam logic [ADDR_W-1:0]  CNT_LAST   = ADDR_W'(BLK - 1);
    localparam logic [PLANE_W-1:0] PLANE_LAST = PLANE_W'(WORD_W - 1);

    always_comb begin
        in_ready   = !st_q.full[st_q.wr_sel];
        wr_fire    = in_valid && in_ready;
        out_valid  = st_q.full[st_q.rd_sel];
        out_last   = out_valid && (st_q.plane == PLANE_LAST);
        wr_sel     = st_q.wr_sel;
        wr_cnt     = st_q.wr_cnt;
        rd_sel     = st_q.rd_sel;
        out_bitidx = st_q.plane;
        swap_pulse = st_q.swap;

        st_d      = st_q;
        st_d.swap = 1'b0;
        if (wr_fire) begin
            st_d.wr_cnt = st_q.wr_cnt + 1'b1;
            if (st_q.wr_cnt == CNT_LAST) begin
                st_d.full[st_q.wr_sel] = 1'b1;
                st_d.wr_sel            = !st_q.wr_sel;
                st_d.swap              = 1'b1;
            end
        end
        if (out_valid && out_ready) begin
            if (st_q.plane == PLANE_LAST) begin
                st_d.plane             = '0;
                st_d.full[st_q.rd_sel] = 1'b0;
                st_d.rd_sel            = !st_q.rd_sel;
            end else begin
                st_d.plane = st_q.plane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    swap_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> out_valid);
    // R5
    plane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && out_bitidx == $past(out_bitidx) + 1'b1));
    // R5
    last_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> (out_bitidx == '0));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bitidx)));
    // R7
    stall_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);
endmodule

// File: rtl/bitplane_pingpong_buf.sv
module bitplane_pingpong_buf
    import bpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [8:0]        in_data,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [63:0]       out_plane,
    output logic [3:0]        out_bitidx,
    output logic              out_last,
    output logic              swap_pulse
);
    logic               wr_fire, wr_sel, rd_sel;
    logic [ADDR_W-1:0]  wr_cnt, slot;
    logic [PLANE_W-1:0] bitidx;
    logic [BLK-1:0]     plane_w [BANKS];

    bpr_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .wr_fire(wr_fire), .wr_sel(wr_sel), .wr_cnt(wr_cnt),
        .rd_sel(rd_sel), .out_valid(out_valid), .out_bitidx(bitidx),
        .out_last(out_last), .swap_pulse(swap_pulse)
    );

    bpr_addr_map map_i (.raster(wr_cnt), .slot(slot));

    for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
        bpr_bank bank_i (
            .clk(clk), .rst_n(rst_n),
            .we(wr_fire && (wr_sel == b[0])),
            .waddr(slot), .wdata(in_data), .rbit(bitidx),
            .plane(plane_w[b])
        );
    end

    assign out_plane  = plane_w[rd_sel];
    assign out_bitidx = bitidx;

    // R6
    plane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_plane));
endmodule

// File: tb/bitplane_pingpong_buf_tb.sv
module bitplane_pingpong_buf_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0, out_ready = 1;
    logic [8:0]  in_data = '0;
    logic        in_ready, out_valid, out_last, swap_pulse;
    logic [63:0] out_plane;
    logic [3:0]  out_bitidx;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    bitplane_pingpong_buf dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int srcidx(input int i);
        return (i < 4) ? 2 * i : 15 - 2 * i;
    endfunction

    function automatic logic [63:0] exp_plane(input logic [575:0] blk, input int k);
        logic [63:0] p;
        for (int a = 0; a < 64; a++) begin
            int s = srcidx(a / 8) * 8 + srcidx(a % 8);
            p[a] = blk[s*9 + k];
        end
        return p;
    endfunction

    task automatic push(input logic [8:0] pix);
        bit r;
        in_valid = 1; in_data = pix;
        forever begin
            r = in_ready;
            @(posedge clk);
            if (r) break;
        end
        @(negedge clk);
    endtask

    task automatic push_block(input logic [575:0] blk);
        for (int j = 0; j < 64; j++) push(blk[j*9 +: 9]);
        in_valid = 0;
    endtask

    task automatic drain(input logic [575:0] blk, input string nm);
        out_ready = 1;
        for (int k = 0; k < 9; k++) begin
            check(out_valid, {"R4/R8 valid ", nm}, 64'(out_valid), 1);
            check(out_bitidx == 4'(k), {"R5 bitidx ", nm}, 64'(out_bitidx), 64'(k));
            check(out_last == (k == 8), {"R5 last ", nm}, 64'(out_last), 64'(k == 8));
            check(out_plane == exp_plane(blk, k), {"R3 plane ", nm}, out_plane, exp_plane(blk, k));
            @(negedge clk);
        end
    endtask

    task automatic run_block(input logic [575:0] blk, input string nm);
        push_block(blk);
        check(swap_pulse == 1, {"R4 swap ", nm}, 64'(swap_pulse), 1);
        drain(blk, nm);
        check(out_valid == 0, {"R9 idle ", nm}, 64'(out_valid), 0);
        check(swap_pulse == 0, {"R4 swap once ", nm}, 64'(swap_pulse), 0);
    endtask

    task automatic test_hold(input logic [575:0] blk);
        logic [63:0] p0;
        out_ready = 0;
        push_block(blk);
        p0 = out_plane;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_valid && out_bitidx == 0 && out_plane == p0, "R6 hold", out_plane, p0);
        end
        drain(blk, "hold");
        check(out_valid == 0, "R9 after hold", 64'(out_valid), 0);
    endtask

    task automatic test_stall(input logic [575:0] a, input logic [575:0] b, input logic [575:0] c);
        out_ready = 0;
        push_block(a);
        push_block(b);
        check(in_ready == 0, "R7 stall", 64'(in_ready), 0);
        check(out_bitidx == 0 && out_plane == exp_plane(a, 0), "R7 first block kept", out_plane, exp_plane(a, 0));
        in_valid = 1; in_data = 9'h155;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(in_ready == 0, "R7 stall held", 64'(in_ready), 0);
        end
        in_valid = 0;
        drain(a, "stallA");
        check(in_ready == 1, "R7 freed", 64'(in_ready), 1);
        drain(b, "seamB R8");
        check(out_valid == 0, "R9 after B", 64'(out_valid), 0);
        run_block(c, "afterstall R7 R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [575:0] ramp, hot, neg, ones, alt;
        for (int j = 0; j < 64; j++) begin
            ramp[j*9 +: 9] = 9'(j);
            hot[j*9 +: 9]  = (j == 13) ? 9'd1 : 9'd0;
            neg[j*9 +: 9]  = 9'(512 - 4 * j - 1);
            ones[j*9 +: 9] = (j == 40) ? 9'd0 : 9'h1FF;
            alt[j*9 +: 9]  = 9'(j * 37 + 5);
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1
        check(out_valid == 0, "R1 valid", 64'(out_valid), 0);
        check(in_ready == 1, "R1 ready", 64'(in_ready), 1);
        check(swap_pulse == 0, "R1 swap", 64'(swap_pulse), 0);
        run_block(ramp, "ramp R2");
        run_block(hot, "onehot");
        run_block(neg, "negative");
        run_block(ones, "ones");
        test_hold(alt);
        test_stall(ramp, neg, alt);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule